// File: doc/BRIEF.md
# Packet Length Header Prepender

This block takes byte-wide packets marked by a valid strobe and start and end flags. It sends each packet out again with a two-byte byte count in front of it. A packet's length is only known once its last byte has arrived, but the length has to lead the output. For that reason every incoming byte is first stored in an internal payload queue, together with its start and end flags.

When a packet ends, its final byte count goes into a separate small length queue. A later packet can therefore never overwrite the count of an earlier packet that is still waiting to go out. The output sequencer works through the lengths in order. For each one it sends the high byte, then the low byte, then the stored payload.

Both directions carry valid only and have no back-pressure. The source may not stall the block, and the sink must accept a beat on every cycle in which `out_valid` is high. Input packets must be 64 to 2048 bytes long. Consecutive input packets must be separated by at least two idle cycles. With these limits the output rate of one packet every length+2 cycles keeps up with the input.

Top module: `pkt_len_prepend`

## Requirements
- R1: While reset is high, and afterwards until a complete packet has been received, `out_valid`, `out_sop` and `out_eop` are low.
- R2: The first output beat of each packet carries bits 15:8 of the packet's byte length on `out_data`, with `out_sop` high and `out_eop` low.
- R3: The second output beat carries bits 7:0 of the byte length, with `out_sop` and `out_eop` both low.
- R4: The payload bytes follow from the third beat onward in their original order. `out_valid` stays high, with no idle cycle, from the high length byte to the last payload byte.
- R5: `out_eop` is high on the last payload byte of each packet and on no other beat.
- R6: Packets of the shortest length (64 bytes) and the longest length (2048 bytes) each come out as exactly length+2 beats, with the correct length header.
- R7: When packets arrive separated by only two to five idle cycles, every packet keeps its own length, and all packets come out in arrival order with none lost.
- R8: When the block is idle, the high length byte appears on the output two clock cycles after the cycle in which the input end beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte present this cycle |
| in_sop | input | 1 | Input byte is the first of its packet |
| in_eop | input | 1 | Input byte is the last of its packet |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output beat present this cycle |
| out_sop | output | 1 | Beat is the high length byte |
| out_eop | output | 1 | Beat is the last payload byte |
| out_data | output | 8 | Length byte or payload byte |

## Verification
A length counter that is off by one shows up at the ports on the very next header, as a low length byte that differs from the number of bytes that follow. A sequencer that pops the payload queue one cycle late shows up at once. The third beat then either repeats a stale byte or leaves a gap after the low length byte. A payload queue pointer that slips, or a length queue entry that gets overwritten, has a later effect. Every following packet then ends on the wrong beat, so the first packet after the fault already shows the wrong `out_eop` position or a shifted byte stream. The run uses random lengths and minimum gaps, plus one packet of each extreme length, so that these faults are reached both with a backlog in the queues and with the queues empty.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 16;

  // One stored payload entry: flags plus the byte.
  typedef struct packed {
    logic              first;
    logic              last;
    logic [BYTE_W-1:0] data;
  } beat_t;

  localparam int BEAT_W = $bits(beat_t);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HI   = 2'd1,
    ST_LO   = 2'd2,
    ST_PAY  = 2'd3
  } ost_t;
endpackage

// File: rtl/pkt_sync_fifo.sv
module pkt_sync_fifo #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             full,
  output logic             empty
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] CAP = (AW+1)'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0] wp, rp, used;
  logic do_wr, do_rd;

  assign used  = wp - rp;
  assign full  = (used == CAP);
  assign empty = (used == '0);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      rd_data <= '0;
    end else begin
      if (do_wr) wp <= wp + 1'b1;
      if (do_rd) begin
        rp      <= rp + 1'b1;
        rd_data <= mem[rp[AW-1:0]];
      end
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
    used <= CAP) else $error("fifo occupancy beyond depth"); // R7
endmodule

// File: rtl/pkt_len_count.sv
module pkt_len_count
  import pkt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic             in_eop,
  output logic             push,
  output logic [LEN_W-1:0] push_len
);
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] nxt;

  assign nxt      = in_sop ? LEN_W'(1) : cnt + 1'b1;
  assign push     = in_valid && in_eop;
  assign push_len = nxt;

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (in_valid) cnt <= nxt;
  end
endmodule

// File: rtl/pkt_out_seq.sv
module pkt_out_seq
  import pkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              len_empty,
  input  logic [LEN_W-1:0]  len_q,
  input  logic              data_empty,
  input  beat_t             data_q,
  output logic              len_pop,
  output logic              data_pop,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_eop,
  output logic [BYTE_W-1:0] out_data
);
  ost_t st, st_n;

  always_comb begin
    st_n     = st;
    len_pop  = 1'b0;
    data_pop = 1'b0;
    unique case (st)
      ST_IDLE: if (!len_empty) begin
        len_pop = 1'b1;
        st_n    = ST_HI;
      end
      ST_HI: st_n = ST_LO;
      ST_LO: begin
        data_pop = 1'b1;
        st_n     = ST_PAY;
      end
      ST_PAY: begin
        if (data_q.last) begin
          if (!len_empty) begin
            len_pop = 1'b1;
            st_n    = ST_HI;
          end else begin
            st_n = ST_IDLE;
          end
        end else begin
          data_pop = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_n;
  end

  always_comb begin
    out_valid = (st != ST_IDLE);
    out_sop   = (st == ST_HI);
    out_eop   = (st == ST_PAY) && data_q.last;
    unique case (st)
      ST_HI:   out_data = len_q[LEN_W-1:BYTE_W];
      ST_LO:   out_data = len_q[BYTE_W-1:0];
      ST_PAY:  out_data = data_q.data;
      default: out_data = '0;
    endcase
  end

  AST_HDR_ORDER: assert property (@(posedge clk) disable iff (rst)
    out_sop |=> out_valid && !out_sop && !out_eop) else $error("low byte missing"); // R3
  AST_SOP_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LO) |=> out_valid && data_q.first) else $error("payload misaligned"); // R4
  AST_DATA_AVAIL: assert property (@(posedge clk) disable iff (rst)
    data_pop |-> !data_empty) else $error("payload underrun"); // R4
  AST_EOP_ENDS: assert property (@(posedge clk) disable iff (rst)
    out_eop |=> !out_valid || out_sop) else $error("beat after end"); // R5
endmodule

// File: rtl/pkt_len_prepend.sv
module pkt_len_prepend
  import pkt_pkg::*;
#(
  parameter int DATA_DEPTH = 4096,
  parameter int LEN_DEPTH  = 16,
  parameter int MIN_LEN    = 64,
  parameter int MAX_LEN    = 2048
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       in_sop,
  input  logic       in_eop,
  input  logic [7:0] in_data,
  output logic       out_valid,
  output logic       out_sop,
  output logic       out_eop,
  output logic [7:0] out_data
);
  logic             push;
  logic [LEN_W-1:0] push_len;
  logic [LEN_W-1:0] len_q;
  logic             len_full, len_empty, len_pop;
  logic [BEAT_W-1:0] d_rd;
  logic             d_full, d_empty, d_pop;
  beat_t            wr_beat, rd_beat;

  assign wr_beat = '{first: in_sop, last: in_eop, data: in_data};
  assign rd_beat = beat_t'(d_rd);

  pkt_len_count u_cnt (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .push(push), .push_len(push_len)
  );

  pkt_sync_fifo #(.WIDTH(BEAT_W), .DEPTH(DATA_DEPTH)) u_data (
    .clk(clk), .rst(rst), .wr_en(in_valid), .wr_data(wr_beat),
    .rd_en(d_pop), .rd_data(d_rd), .full(d_full), .empty(d_empty)
  );

  pkt_sync_fifo #(.WIDTH(LEN_W), .DEPTH(LEN_DEPTH)) u_len (
    .clk(clk), .rst(rst), .wr_en(push), .wr_data(push_len),
    .rd_en(len_pop), .rd_data(len_q), .full(len_full), .empty(len_empty)
  );

  pkt_out_seq u_seq (
    .clk(clk), .rst(rst), .len_empty(len_empty), .len_q(len_q),
    .data_empty(d_empty), .data_q(rd_beat), .len_pop(len_pop),
    .data_pop(d_pop), .out_valid(out_valid), .out_sop(out_sop),
    .out_eop(out_eop), .out_data(out_data)
  );

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
    push |-> (push_len >= LEN_W'(MIN_LEN)) && (push_len <= LEN_W'(MAX_LEN))) else $error("length out of range"); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && d_full) && !(push && len_full)) else $error("queue overflow"); // R7
endmodule

// File: tb/sim_pkt_len_prepend.sv
`timescale 1ns/1ps
module sim_pkt_len_prepend;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0] in_data = '0;
  logic out_valid, out_sop, out_eop;
  logic [7:0] out_data;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [9:0] exp_q[$];
  int exp_len[$];
  int sent = 0, rcvd = 0;
  int mcyc = 0, eop_at = -1, pos = 0;
  bit in_pkt = 0, lat_arm = 1;

  always #2 clk = ~clk;

  pkt_len_prepend u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_data(in_data), .out_valid(out_valid),
    .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, mcyc);
    end
  endtask

  function automatic logic [9:0] hdr_beat(input int len, input bit hi);
    return hi ? {2'b10, 8'(len >> 8)} : {2'b00, 8'(len)};
  endfunction

  task automatic send_pkt(input int len, input int gap);
    exp_q.push_back(hdr_beat(len, 1));
    exp_q.push_back(hdr_beat(len, 0));
    exp_len.push_back(len);
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1;
      in_sop   = (i == 0);
      in_eop   = (i == len - 1);
      in_data  = 8'($urandom);
      exp_q.push_back({1'b0, in_eop, in_data});
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    repeat (gap - 1) @(posedge clk);
    sent++;
  endtask

  // Output monitor, sampled away from the rising edge.
  always @(negedge clk) begin
    if (!rst) begin
      mcyc++;
      if (lat_arm && in_valid && in_eop) eop_at = mcyc;
      if (lat_arm && out_sop && eop_at >= 0) begin
        chk(mcyc == eop_at + 2, "R8 header latency", mcyc - eop_at, 2);
        lat_arm = 0;
      end
      if (in_pkt && !out_valid) chk(0, "R4 gap inside packet", 0, 1);
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          chk(0, "R7 unexpected beat", {out_sop, out_eop, out_data}, 0);
        end else begin
          logic [9:0] e;
          string tag;
          e = exp_q.pop_front();
          tag = (pos == 0) ? "R2 high length byte" : (pos == 1) ? "R3 low length byte" :
                e[8] ? "R5 last payload byte" : "R4 payload byte";
          chk({out_sop, out_eop, out_data} == e, tag, {out_sop, out_eop, out_data}, e);
          pos++;
          in_pkt = 1;
          if (e[8]) begin
            int el;
            el = (exp_len.size() > 0) ? exp_len.pop_front() : -1;
            chk(pos == el + 2, "R6 beats per packet", pos, el + 2);
            pos = 0;
            in_pkt = 0;
            rcvd++;
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      chk(0, "R7 watchdog expired", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int len, gap;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid && !out_sop && !out_eop, "R1 outputs in reset", out_valid, 0);
    @(posedge clk); #1 rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(!out_valid && !out_sop && !out_eop, "R1 idle after reset", out_valid, 0);
    // Directed extremes, first one from idle for the latency check.
    send_pkt(64, 2);
    send_pkt(2048, 2);
    send_pkt(64, 3);
    // Random lengths with short gaps.
    for (int k = 0; k < 25; k++) begin
      len = 64 + int'($urandom % 337);
      gap = 2 + int'($urandom % 4);
      send_pkt(len, gap);
    end
    send_pkt(2048, 2);
    for (int w = 0; w < 20000 && exp_q.size() != 0; w++) @(posedge clk);
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all beats delivered", exp_q.size(), 0);
    chk(rcvd == sent, "R7 packet count", rcvd, sent);
    chk(!out_valid, "R1 idle when drained", out_valid, 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule